// File: doc/BRIEF.md
# USB-C Port Negotiation and Attach Status Indicators

This block turns single-cycle event strobes from a USB Type-C / Power Delivery protocol engine into steady, registered status levels for one port. The engine pulses a strobe when a power Request is received or is about to be sent, when Accept or PS_RDY is sent, when PS_RDY is received, and on attach, detach and hard reset. Level inputs give the present power role, data role, CC orientation and accessory type. From these the block drives a negotiation-busy flag, a sinking-from-a-source flag, an enable for an external USB 2.0 D+/D- switch, a UFP flag, a flipped-plug flag, a plug-present flag, and two accessory flags.

The negotiation flag follows different start and end events depending on the power role. When sourcing, it covers the span from the received Request to the PS_RDY the port sends. When sinking, it covers the span from the Request the port sends to the PS_RDY it receives. An active-low fault input is synchronized, and each falling edge of it produces a one-cycle request to enter Type-C error recovery.

Top module: `pd_status_ind`

## Requirements
- R1: With `role_src`=1, `nego_busy` rises on the edge after `ev_req_rx` and falls on the edge after `ev_psrdy_tx`. In this role, `ev_req_tx` and `ev_psrdy_rx` have no effect on it.
- R2: With `role_src`=0, `nego_busy` rises on the edge after `ev_req_tx` and falls on the edge after `ev_psrdy_rx`. In this role, `ev_req_rx` and `ev_psrdy_tx` have no effect on it.
- R3: `ev_detach` or `ev_hard_rst` forces `nego_busy` low on the next edge. This takes priority over any other strobe in the same cycle.
- R4: `sink_attached` goes high on the edge after `ev_attach` while `role_src`=0. It goes low on the edge after `ev_detach` or `ev_hard_rst`, or after any cycle in which `role_src`=1.
- R5: `plug_on` and `usb2_mux_en` go high on the edge after `ev_attach` and low on the edge after `ev_detach`. Detach wins when both strobes arrive in the same cycle. A hard reset does not change them.
- R6: `orient_flip` is high only while attached and `cc_flip`=1, where `cc_flip`=1 means CC2 is in use. It is low when the plug is upright or nothing is attached.
- R7: `ufp_ind` follows `role_ufp` with one cycle of delay.
- R8: `acc_type` is encoded as 2'b01 debug, 2'b10 audio, and 2'b00/2'b11 none. `dbg_acc` and `aud_acc` are high only while attached with the matching code.
- R9: A falling edge on `fault_n` gives exactly one single-cycle `err_recov_req` pulse within SYNC_STAGES+2 cycles. A level held low or high gives no further pulse.
- R10: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_req_rx | input | 1 | Strobe: Request message received |
| ev_req_tx | input | 1 | Strobe: Request message about to be sent |
| ev_accept_tx | input | 1 | Strobe: Accept message sent |
| ev_psrdy_tx | input | 1 | Strobe: PS_RDY sent |
| ev_psrdy_rx | input | 1 | Strobe: PS_RDY received |
| ev_attach | input | 1 | Strobe: partner attached |
| ev_detach | input | 1 | Strobe: partner detached |
| ev_hard_rst | input | 1 | Strobe: hard reset |
| role_src | input | 1 | Power role: 1 source, 0 sink |
| role_ufp | input | 1 | Data role: 1 UFP, 0 DFP |
| cc_flip | input | 1 | 1 when CC2 carries the connection |
| acc_type | input | 2 | Accessory code (see R8) |
| fault_n | input | 1 | Asynchronous active-low fault |
| nego_busy | output | 1 | Power negotiation in progress |
| sink_attached | output | 1 | Attached and sinking from a source |
| usb2_mux_en | output | 1 | D+/D- switch enable |
| ufp_ind | output | 1 | Data role is UFP |
| orient_flip | output | 1 | Plug flipped (CC2) |
| plug_on | output | 1 | Partner attached |
| dbg_acc | output | 1 | Debug accessory attached |
| aud_acc | output | 1 | Audio accessory attached |
| err_recov_req | output | 1 | One-cycle error-recovery request |

## Verification
The hardest cases to reach are the ones where the same strobe is allowed or ignored depending on the power role. Reaching them takes a full sink-side negotiation, then a role change mid-attach, then a source-side negotiation, with each role's strobes fed while the other role is active. The stimulus also sets up collisions that can only happen in a single cycle: a request strobe together with a hard reset, and attach together with detach. Fault edges are applied as held levels that last longer than the synchronizer, so pulses can be counted over whole windows.

// File: rtl/pd_ind_pkg.sv
package pd_ind_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_DEBUG = 2'b01,
    ACC_AUDIO = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic req_rx;
    logic req_tx;
    logic accept_tx;
    logic psrdy_tx;
    logic psrdy_rx;
    logic attach;
    logic detach;
    logic hard_rst;
  } pd_evt_t;
endpackage

// File: rtl/pd_nego_track.sv
module pd_nego_track
  import pd_ind_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pd_evt_t evt,
  input  logic    role_src,
  output logic    nego_busy
);
  logic busy_q, busy_d;
  logic rise, fall;

  always_comb begin
    if (role_src) begin
      rise = evt.req_rx;
      fall = evt.psrdy_tx;
    end else begin
      rise = evt.req_tx;
      fall = evt.psrdy_rx;
    end
  end

  always_comb begin
    busy_d = busy_q;
    if (evt.detach || evt.hard_rst) busy_d = 1'b0;
    else if (rise)                  busy_d = 1'b1;
    else if (fall)                  busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign nego_busy = busy_q;

  a_r1_src_request_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (role_src && evt.req_rx && !evt.detach && !evt.hard_rst) |=> nego_busy);
  a_r2_sink_request_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_src && evt.req_tx && !evt.detach && !evt.hard_rst) |=> nego_busy);
  a_r3_detach_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.detach || evt.hard_rst) |=> !nego_busy);
endmodule

// File: rtl/pd_attach_track.sv
module pd_attach_track
  import pd_ind_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pd_evt_t   evt,
  input  logic      role_src,
  input  logic      role_ufp,
  input  logic      cc_flip,
  input  acc_kind_e acc_type,
  output logic      attached,
  output logic      sink_attached,
  output logic      ufp_ind,
  output logic      orient_flip,
  output logic      dbg_acc,
  output logic      aud_acc
);
  logic att_q, att_d;
  logic sink_q, sink_d;
  logic ufp_q, orient_q, orient_d;
  logic dbg_q, dbg_d, aud_q, aud_d;

  always_comb begin
    att_d = att_q;
    if (evt.detach)      att_d = 1'b0;
    else if (evt.attach) att_d = 1'b1;
  end

  always_comb begin
    sink_d = sink_q;
    if (evt.detach || evt.hard_rst) sink_d = 1'b0;
    else if (role_src)              sink_d = 1'b0;
    else if (evt.attach)            sink_d = 1'b1;
  end

  always_comb begin
    orient_d = att_d & cc_flip;
    dbg_d    = att_d & (acc_type == ACC_DEBUG);
    aud_d    = att_d & (acc_type == ACC_AUDIO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_q    <= 1'b0;
      sink_q   <= 1'b0;
      ufp_q    <= 1'b0;
      orient_q <= 1'b0;
      dbg_q    <= 1'b0;
      aud_q    <= 1'b0;
    end else begin
      att_q    <= att_d;
      sink_q   <= sink_d;
      ufp_q    <= role_ufp;
      orient_q <= orient_d;
      dbg_q    <= dbg_d;
      aud_q    <= aud_d;
    end
  end

  assign attached      = att_q;
  assign sink_attached = sink_q;
  assign ufp_ind       = ufp_q;
  assign orient_flip   = orient_q;
  assign dbg_acc       = dbg_q;
  assign aud_acc       = aud_q;

  a_r4_sink_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.detach || evt.hard_rst || role_src) |=> !sink_attached);
  a_r5_detach_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt.detach |=> !attached);
  a_r7_ufp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ufp_ind == $past(role_ufp)));
  a_r8_acc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_acc && aud_acc));
endmodule

// File: rtl/pd_fault_edge.sv
module pd_fault_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_n,
  output logic err_pulse
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;
  logic          pulse_q, pulse_d;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= fault_n;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b1;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_comb pulse_d = prev_q & ~sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= sync_q[LAST];
      pulse_q <= pulse_d;
    end
  end

  assign err_pulse = pulse_q;

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
endmodule

// File: rtl/pd_status_ind.sv
module pd_status_ind
  import pd_ind_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_req_rx,
  input  logic       ev_req_tx,
  input  logic       ev_accept_tx,
  input  logic       ev_psrdy_tx,
  input  logic       ev_psrdy_rx,
  input  logic       ev_attach,
  input  logic       ev_detach,
  input  logic       ev_hard_rst,
  input  logic       role_src,
  input  logic       role_ufp,
  input  logic       cc_flip,
  input  logic [1:0] acc_type,
  input  logic       fault_n,
  output logic       nego_busy,
  output logic       sink_attached,
  output logic       usb2_mux_en,
  output logic       ufp_ind,
  output logic       orient_flip,
  output logic       plug_on,
  output logic       dbg_acc,
  output logic       aud_acc,
  output logic       err_recov_req
);
  pd_evt_t evt;
  logic    attached;

  always_comb begin
    evt.req_rx    = ev_req_rx;
    evt.req_tx    = ev_req_tx;
    evt.accept_tx = ev_accept_tx;
    evt.psrdy_tx  = ev_psrdy_tx;
    evt.psrdy_rx  = ev_psrdy_rx;
    evt.attach    = ev_attach;
    evt.detach    = ev_detach;
    evt.hard_rst  = ev_hard_rst;
  end

  pd_nego_track u_nego (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .role_src  (role_src),
    .nego_busy (nego_busy)
  );

  pd_attach_track u_att (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt           (evt),
    .role_src      (role_src),
    .role_ufp      (role_ufp),
    .cc_flip       (cc_flip),
    .acc_type      (acc_kind_e'(acc_type)),
    .attached      (attached),
    .sink_attached (sink_attached),
    .ufp_ind       (ufp_ind),
    .orient_flip   (orient_flip),
    .dbg_acc       (dbg_acc),
    .aud_acc       (aud_acc)
  );

  pd_fault_edge #(.SYNC_STAGES(SYNC_STAGES)) u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_n   (fault_n),
    .err_pulse (err_recov_req)
  );

  assign plug_on     = attached;
  assign usb2_mux_en = attached;

  a_r6_orient_needs_plug: assert property (@(posedge clk) disable iff (!rst_n)
    orient_flip |-> plug_on);
  a_r8_acc_needs_plug: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_acc || aud_acc) |-> plug_on);
  a_r5_hard_reset_keeps_plug: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hard_rst && !ev_detach && !ev_attach) |=> (plug_on == $past(plug_on)));
endmodule

// File: tb/pd_status_ind_test.sv
module pd_status_ind_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] stb;
  logic role_src, role_ufp, cc_flip, fault_n;
  logic [1:0] acc_type;
  logic nego_busy, sink_attached, usb2_mux_en, ufp_ind;
  logic orient_flip, plug_on, dbg_acc, aud_acc, err_recov_req;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // stb order: req_rx, req_tx, accept_tx, psrdy_tx, psrdy_rx, attach, detach, hard_rst
  pd_status_ind uut (
    .clk(clk), .rst_n(rst_n),
    .ev_req_rx(stb[7]), .ev_req_tx(stb[6]), .ev_accept_tx(stb[5]),
    .ev_psrdy_tx(stb[4]), .ev_psrdy_rx(stb[3]), .ev_attach(stb[2]),
    .ev_detach(stb[1]), .ev_hard_rst(stb[0]),
    .role_src(role_src), .role_ufp(role_ufp), .cc_flip(cc_flip),
    .acc_type(acc_type), .fault_n(fault_n),
    .nego_busy(nego_busy), .sink_attached(sink_attached),
    .usb2_mux_en(usb2_mux_en), .ufp_ind(ufp_ind), .orient_flip(orient_flip),
    .plug_on(plug_on), .dbg_acc(dbg_acc), .aud_acc(aud_acc),
    .err_recov_req(err_recov_req)
  );

  // expected order: nego, sink, mux, ufp, orient, plug, dbg, aud
  always @(posedge clk) begin
    #2;
    if (err_recov_req) pulses++;
    if (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb.pop_front();
      act = {nego_busy, sink_attached, usb2_mux_en, ufp_ind,
             orient_flip, plug_on, dbg_acc, aud_acc};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%b expected=%b", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(input logic [7:0] s, input logic [7:0] e, input string tag);
    @(negedge clk);
    stb = s;
    sb.push_back('{e, tag});
    @(negedge clk);
    stb = 8'h00;
  endtask

  task automatic check1(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic fault_level(input logic lvl, input int expect_pulses, input string tag);
    @(negedge clk);
    fault_n = lvl;
    repeat (8) @(negedge clk);
    total++;
    if (pulses != expect_pulses) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d pulses", tag, pulses, expect_pulses);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stb = 8'h00; role_src = 1'b0; role_ufp = 1'b1;
    cc_flip = 1'b1; acc_type = 2'b00; fault_n = 1'b1;
    repeat (3) @(negedge clk);
    check1(|{nego_busy, sink_attached, usb2_mux_en, ufp_ind, orient_flip,
             plug_on, dbg_acc, aud_acc, err_recov_req}, 1'b0, "R10 reset low");
    rst_n = 1'b1;
    @(negedge clk);
    sb.delete();

    // sink-side negotiation
    step(8'b0000_0100, 8'b0111_1100, "R4 R5 R6 R7 attach as sink");
    step(8'b0100_0000, 8'b1111_1100, "R2 request sent");
    step(8'b1001_0000, 8'b1111_1100, "R2 source strobes ignored");
    step(8'b0000_1000, 8'b0111_1100, "R2 psrdy received");
    // role swap to source, data role to DFP
    role_src = 1'b1; role_ufp = 1'b0;
    step(8'b0000_0000, 8'b0010_1100, "R4 R7 swap leaves sink");
    step(8'b1000_0000, 8'b1010_1100, "R1 request received");
    step(8'b0010_0000, 8'b1010_1100, "R1 accept holds");
    step(8'b0000_1000, 8'b1010_1100, "R1 sink psrdy ignored");
    step(8'b0001_0000, 8'b0010_1100, "R1 psrdy sent");
    step(8'b0100_0000, 8'b0010_1100, "R1 sink request ignored");
    step(8'b1000_0001, 8'b0010_1100, "R3 hard reset beats request");
    step(8'b1000_0000, 8'b1010_1100, "R1 request again");
    step(8'b0000_0001, 8'b0010_1100, "R3 R5 hard reset keeps plug");
    cc_flip = 1'b0;
    step(8'b0000_0000, 8'b0010_0100, "R6 upright plug");
    step(8'b1000_0110, 8'b0000_0000, "R3 R5 detach beats attach");
    step(8'b0000_0100, 8'b0010_0100, "R5 reattach as source");
    step(8'b1000_0000, 8'b1010_0100, "R1 request received");
    step(8'b0000_0010, 8'b0000_0000, "R3 detach clears nego");
    // accessories
    acc_type = 2'b01;
    step(8'b0000_0100, 8'b0010_0110, "R8 debug accessory");
    acc_type = 2'b10;
    step(8'b0000_0000, 8'b0010_0101, "R8 audio accessory");
    acc_type = 2'b11;
    step(8'b0000_0000, 8'b0010_0100, "R8 reserved code none");
    acc_type = 2'b10; cc_flip = 1'b1;
    step(8'b0000_0010, 8'b0000_0000, "R6 R8 detached no flags");
    // sink detach
    role_src = 1'b0; acc_type = 2'b00;
    step(8'b0000_0100, 8'b0110_1100, "R4 attach as sink");
    step(8'b0000_0010, 8'b0000_0000, "R4 R5 detach clears sink");
    @(negedge clk);

    // fault input
    pulses = 0;
    fault_level(1'b0, 1, "R9 falling edge pulse");
    fault_level(1'b0, 1, "R9 held low no repeat");
    fault_level(1'b1, 1, "R9 high no action");
    fault_level(1'b0, 2, "R9 second falling edge");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule